// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR4 memory interface. It takes the memory device from power-on reset to a state where normal traffic may start. After system reset it holds the memory reset pin low for a programmable time and then releases it. After a further wait it enables the memory clock. Once that clock has run for its settling time, it raises the clock-enable pin.

With clock enable high, the block waits out the reset-exit time. It then writes the seven mode registers in the order the device requires, leaving a programmable gap after each write. It issues a long ZQ calibration and waits out the longer of the DLL-lock and ZQ-init windows. At that point it raises a sticky done flag. Every delay is a count of controller clock cycles, set by a parameter. Each mode-register value comes in on its own slice of a flat input bus.

Every output is registered, so the spacing between any two events on the pins is exactly the number of cycles programmed. The on-die termination pin is driven to one static level for the whole sequence. That level is forced low when the MR1 value enables nominal termination.

Top module: `ddr4_init_seq`

## Requirements
- R1: After system reset is released, `mem_reset_n` stays low for at least `T_RST_HOLD` cycles. `ck_en` and `cke` stay low during that time.
- R2: `ck_en` rises exactly `T_CKE_WAIT` cycles after `mem_reset_n` rises.
- R3: `cke` rises exactly `T_CLK_STABLE` cycles after `ck_en` rises. Once high, `ck_en` stays high.
- R4: In the cycle in which `cke` is first high, the command bus carries DESELECT (`cs_n`=1). Every cycle that carries no MRS or ZQCL command also has `cs_n`=1.
- R5: Once `cke` is high it stays high through the whole sequence and after `init_done`.
- R6: The first MRS comes exactly `T_XPR` cycles after `cke` rises. An MRS is encoded as `cs_n`=0, `act_n`=1, `ras_n`=0, `cas_n`=0, `we_n`=0. Its fields are: `bg[1]`=0, `bg[0]` = register number bit 2, `ba` = register number bits 1:0, and `addr` = the register's value. Register k's value is `mr_values[k*ADDR_W +: ADDR_W]`.
- R7: Mode registers are written in the order 3, 6, 5, 4, 2, 1, 0. Successive MRS commands are exactly `T_MRD` cycles apart.
- R8: One ZQCL command follows exactly `T_MOD` cycles after the MR0 write. It is encoded as `cs_n`=0, `act_n`=1, `ras_n`=1, `cas_n`=1, `we_n`=0, with `addr` bit 10 = 1, all other `addr` bits 0, and `bg`=`ba`=0.
- R9: `init_done` rises exactly max(`T_DLLK`, `T_ZQINIT`) cycles after ZQCL and stays high. Exactly eight commands are issued in all.
- R10: From the cycle `cke` rises, `odt` is constant. It equals `ODT_IDLE_HIGH`, except that it is 0 whenever bits 10:8 of the MR1 value are nonzero.
- R11: Synchronous reset asserted at any point returns the outputs, one clock later, to `mem_reset_n`=0, `ck_en`=0, `cke`=0, `cs_n`=1, `init_done`=0. The whole sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_values | input | 7*ADDR_W | Mode-register values, register k in slice k |
| mem_reset_n | output | 1 | Memory reset pin, active low |
| ck_en | output | 1 | Enable for the memory clock driver |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination control, held static |
| cs_n | output | 1 | Chip select, active low |
| act_n | output | 1 | Activate line of the command |
| ras_n | output | 1 | RAS line of the command |
| cas_n | output | 1 | CAS line of the command |
| we_n | output | 1 | WE line of the command |
| bg | output | 2 | Bank-group field |
| ba | output | 2 | Bank field |
| addr | output | ADDR_W | Address field |
| init_done | output | 1 | High once initialization is complete, sticky |

## Verification
The assertions assume that `mr_values` holds still from reset release until `init_done`. They also assume every timing parameter is at least 2, except `T_CKE_WAIT` and `T_CLK_STABLE`, which must be at least 1. The bench picks its register values from a seeded random source once per run and changes them only while reset is asserted. Its timing parameters are small values that meet these minimums. One run forces MR1 bits 10:8 to zero and another forces them nonzero, so both ODT levels are exercised. A further run breaks into the sequence with reset partway through.

// File: rtl/ddr4_init_pkg.sv
package ddr4_init_pkg;

  localparam int MR_COUNT = 7;

  typedef enum logic [3:0] {
    ST_RST,
    ST_PRECK,
    ST_CLKRUN,
    ST_CKEUP,
    ST_XPR,
    ST_MRS,
    ST_MRGAP,
    ST_ZQCL,
    ST_FINAL,
    ST_DONE
  } init_state_e;

  // Register number written at each step of the load sequence.
  function automatic logic [2:0] mr_at_step(input logic [2:0] step);
    logic [2:0] r;
    case (step)
      3'd0:    r = 3'd3;
      3'd1:    r = 3'd6;
      3'd2:    r = 3'd5;
      3'd3:    r = 3'd4;
      3'd4:    r = 3'd2;
      3'd5:    r = 3'd1;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int          CNT_W    = 8,
  parameter logic [CNT_W-1:0] RST_LOAD = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= RST_LOAD;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R2
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);

endmodule

// File: rtl/init_fsm.sv
module init_fsm
  import ddr4_init_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int T_CKE_WAIT   = 4,
  parameter int T_CLK_STABLE = 4,
  parameter int T_XPR        = 4,
  parameter int T_MRD        = 4,
  parameter int T_MOD        = 4,
  parameter int T_FINAL      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expired,
  output init_state_e      state,
  output logic [2:0]       step,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  localparam logic [CNT_W-1:0] LD_CKEW  = CNT_W'(T_CKE_WAIT - 1);
  localparam logic [CNT_W-1:0] LD_CLK   = CNT_W'(T_CLK_STABLE - 1);
  localparam logic [CNT_W-1:0] LD_XPR   = CNT_W'(T_XPR - 2);
  localparam logic [CNT_W-1:0] LD_MRD   = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] LD_MOD   = CNT_W'(T_MOD - 2);
  localparam logic [CNT_W-1:0] LD_FINAL = CNT_W'(T_FINAL - 2);
  localparam logic [2:0]       LAST_STEP = 3'(MR_COUNT - 1);

  init_state_e state_q, state_d;
  logic [2:0]  step_q, step_d;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_RST: if (expired) begin
        state_d = ST_PRECK; load = 1'b1; load_val = LD_CKEW;
      end
      ST_PRECK: if (expired) begin
        state_d = ST_CLKRUN; load = 1'b1; load_val = LD_CLK;
      end
      ST_CLKRUN: if (expired) state_d = ST_CKEUP;
      ST_CKEUP: begin
        state_d = ST_XPR; load = 1'b1; load_val = LD_XPR;
      end
      ST_XPR: if (expired) state_d = ST_MRS;
      ST_MRS: begin
        state_d  = ST_MRGAP;
        load     = 1'b1;
        load_val = (step_q == LAST_STEP) ? LD_MOD : LD_MRD;
      end
      ST_MRGAP: if (expired) begin
        if (step_q == LAST_STEP) state_d = ST_ZQCL;
        else begin
          state_d = ST_MRS;
          step_d  = step_q + 3'd1;
        end
      end
      ST_ZQCL: begin
        state_d = ST_FINAL; load = 1'b1; load_val = LD_FINAL;
      end
      ST_FINAL: if (expired) state_d = ST_DONE;
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RST;
      step_q  <= 3'd0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign state = state_q;
  assign step  = step_q;

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q <= LAST_STEP));

  // R9
  done_terminal_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> (state_q == ST_DONE));

endmodule

// File: rtl/init_cmd_enc.sv
module init_cmd_enc
  import ddr4_init_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter bit ODT_IDLE_HIGH = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  init_state_e                  state,
  input  logic [2:0]                   step,
  input  logic [MR_COUNT*ADDR_W-1:0]   mr_values,
  output logic                         mem_reset_n,
  output logic                         ck_en,
  output logic                         cke,
  output logic                         odt,
  output logic                         cs_n,
  output logic                         act_n,
  output logic                         ras_n,
  output logic                         cas_n,
  output logic                         we_n,
  output logic [1:0]                   bg,
  output logic [1:0]                   ba,
  output logic [ADDR_W-1:0]            addr,
  output logic                         init_done
);

  logic [ADDR_W-1:0] mr_arr [MR_COUNT];

  genvar gi;
  generate
    for (gi = 0; gi < MR_COUNT; gi++) begin : g_unpack
      assign mr_arr[gi] = mr_values[gi*ADDR_W +: ADDR_W];
    end
  endgenerate

  logic [2:0]        mr_num;
  logic [ADDR_W-1:0] zq_addr;
  logic              rtt_nom_on;
  logic              pre_cke;

  assign mr_num     = mr_at_step(step);
  assign zq_addr    = ADDR_W'(1) << 10;
  assign rtt_nom_on = |mr_arr[1][10:8];
  assign pre_cke    = (state == ST_RST) || (state == ST_PRECK) || (state == ST_CLKRUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_reset_n <= 1'b0;
      ck_en       <= 1'b0;
      cke         <= 1'b0;
      odt         <= 1'b0;
      cs_n        <= 1'b1;
      act_n       <= 1'b1;
      ras_n       <= 1'b1;
      cas_n       <= 1'b1;
      we_n        <= 1'b1;
      bg          <= 2'b00;
      ba          <= 2'b00;
      addr        <= '0;
      init_done   <= 1'b0;
    end else begin
      mem_reset_n <= (state != ST_RST);
      ck_en       <= (state != ST_RST) && (state != ST_PRECK);
      cke         <= !pre_cke;
      odt         <= ODT_IDLE_HIGH && !rtt_nom_on;
      init_done   <= (state == ST_DONE);
      act_n       <= 1'b1;
      bg          <= 2'b00;
      ba          <= 2'b00;
      addr        <= '0;
      cs_n        <= 1'b1;
      ras_n       <= 1'b1;
      cas_n       <= 1'b1;
      we_n        <= 1'b1;
      if (state == ST_MRS) begin
        cs_n  <= 1'b0;
        ras_n <= 1'b0;
        cas_n <= 1'b0;
        we_n  <= 1'b0;
        bg    <= {1'b0, mr_num[2]};
        ba    <= mr_num[1:0];
        addr  <= mr_arr[mr_num];
      end else if (state == ST_ZQCL) begin
        cs_n  <= 1'b0;
        we_n  <= 1'b0;
        addr  <= zq_addr;
      end
    end
  end

  // R3
  ck_en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ck_en |=> ck_en);

  // R4
  desel_on_cke_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> cs_n);

  // R5
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R6
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (cke && mem_reset_n && ck_en));

  // R10
  odt_static_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> $stable(odt));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

endmodule

// File: rtl/ddr4_init_seq.sv
module ddr4_init_seq
  import ddr4_init_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter bit ODT_IDLE_HIGH = 1'b0,
  parameter int T_RST_HOLD    = 160000,
  parameter int T_CKE_WAIT    = 400000,
  parameter int T_CLK_STABLE  = 8,
  parameter int T_XPR         = 288,
  parameter int T_MRD         = 8,
  parameter int T_MOD         = 24,
  parameter int T_DLLK        = 1024,
  parameter int T_ZQINIT      = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [7*ADDR_W-1:0]        mr_values,
  output logic                       mem_reset_n,
  output logic                       ck_en,
  output logic                       cke,
  output logic                       odt,
  output logic                       cs_n,
  output logic                       act_n,
  output logic                       ras_n,
  output logic                       cas_n,
  output logic                       we_n,
  output logic [1:0]                 bg,
  output logic [1:0]                 ba,
  output logic [ADDR_W-1:0]          addr,
  output logic                       init_done
);

  localparam int T_FINAL = (T_DLLK > T_ZQINIT) ? T_DLLK : T_ZQINIT;
  localparam int M1      = (T_RST_HOLD > T_CKE_WAIT) ? T_RST_HOLD : T_CKE_WAIT;
  localparam int M2      = (T_XPR > T_FINAL) ? T_XPR : T_FINAL;
  localparam int M3      = (T_MOD > T_MRD) ? T_MOD : T_MRD;
  localparam int M4      = (M1 > M2) ? M1 : M2;
  localparam int M5      = (M3 > T_CLK_STABLE) ? M3 : T_CLK_STABLE;
  localparam int LONGEST = (M4 > M5) ? M4 : M5;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(T_RST_HOLD - 1);

  init_state_e      state;
  logic [2:0]       step;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  init_timer #(
    .CNT_W    (CNT_W),
    .RST_LOAD (RST_LOAD)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  init_fsm #(
    .CNT_W        (CNT_W),
    .T_CKE_WAIT   (T_CKE_WAIT),
    .T_CLK_STABLE (T_CLK_STABLE),
    .T_XPR        (T_XPR),
    .T_MRD        (T_MRD),
    .T_MOD        (T_MOD),
    .T_FINAL      (T_FINAL)
  ) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .expired  (expired),
    .state    (state),
    .step     (step),
    .load     (load),
    .load_val (load_val)
  );

  init_cmd_enc #(
    .ADDR_W        (ADDR_W),
    .ODT_IDLE_HIGH (ODT_IDLE_HIGH)
  ) enc_i (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .step        (step),
    .mr_values   (mr_values),
    .mem_reset_n (mem_reset_n),
    .ck_en       (ck_en),
    .cke         (cke),
    .odt         (odt),
    .cs_n        (cs_n),
    .act_n       (act_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .bg          (bg),
    .ba          (ba),
    .addr        (addr),
    .init_done   (init_done)
  );

  // R1
  rst_first_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_reset_n |-> (!ck_en && !cke));

endmodule

// File: tb/ddr4_init_seq_tb_top.sv
module ddr4_init_seq_tb_top;

  localparam int AW     = 18;
  localparam int T_RST  = 20;
  localparam int T_CKEW = 30;
  localparam int T_CLK  = 5;
  localparam int T_XPR  = 8;
  localparam int T_MRD  = 4;
  localparam int T_MOD  = 6;
  localparam int T_DLLK = 40;
  localparam int T_ZQI  = 25;
  localparam int T_FIN  = (T_DLLK > T_ZQI) ? T_DLLK : T_ZQI;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst;
  logic [7*AW-1:0] mr_flat;
  logic            mem_reset_n, ck_en, cke, odt, cs_n, act_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]      bg, ba;
  logic [AW-1:0]   addr;
  logic [AW-1:0]   mr_vals [7];

  int checks = 0;
  int errors = 0;

  ddr4_init_seq #(
    .ADDR_W        (AW),
    .ODT_IDLE_HIGH (1'b1),
    .T_RST_HOLD    (T_RST),
    .T_CKE_WAIT    (T_CKEW),
    .T_CLK_STABLE  (T_CLK),
    .T_XPR         (T_XPR),
    .T_MRD         (T_MRD),
    .T_MOD         (T_MOD),
    .T_DLLK        (T_DLLK),
    .T_ZQINIT      (T_ZQI)
  ) dut_i (
    .clk (clk), .rst (rst), .mr_values (mr_flat),
    .mem_reset_n (mem_reset_n), .ck_en (ck_en), .cke (cke), .odt (odt),
    .cs_n (cs_n), .act_n (act_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .bg (bg), .ba (ba), .addr (addr), .init_done (init_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int order_at(input int n);
    case (n)
      0: return 3; 1: return 6; 2: return 5; 3: return 4;
      4: return 2; 5: return 1; default: return 0;
    endcase
  endfunction

  function automatic bit exp_odt(input logic [AW-1:0] mr1);
    return (mr1[10:8] == 3'b000);
  endfunction

  task automatic load_vals(input bit rtt_on);
    for (int k = 0; k < 7; k++) mr_vals[k] = AW'($urandom);
    if (rtt_on) mr_vals[1][10:8] = 3'b010;
    else        mr_vals[1][10:8] = 3'b000;
    for (int k = 0; k < 7; k++) mr_flat[k*AW +: AW] = mr_vals[k];
  endtask

  task automatic check_reset_state(input string req);
    chk(mem_reset_n == 1'b0, req, mem_reset_n, 0);
    chk(ck_en == 1'b0 && cke == 1'b0, req, {ck_en, cke}, 0);
    chk(cs_n == 1'b1, req, cs_n, 1);
    chk(init_done == 1'b0, req, init_done, 0);
  endtask

  task automatic run_seq(input int abort_at);
    int t_rel, t_ck, t_cke, t_prev, t_zq, t_done, n_cmd, low_cnt;
    bit seen_rel, seen_ck, seen_cke, seen_done, cke_drop, odt_ref;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check_reset_state("R11");
    rst = 1'b0;
    t_rel = 0; t_ck = 0; t_cke = 0; t_prev = 0; t_zq = 0; t_done = 0;
    n_cmd = 0; low_cnt = 0;
    seen_rel = 0; seen_ck = 0; seen_cke = 0; seen_done = 0; cke_drop = 0; odt_ref = 0;
    for (int t = 1; t < 3000; t++) begin
      @(negedge clk);
      if (abort_at != 0 && t == abort_at) begin
        rst = 1'b1;
        @(negedge clk);
        // R11 mid-sequence reset
        check_reset_state("R11");
        rst = 1'b0;
        return;
      end
      if (!seen_rel) begin
        if (!mem_reset_n) begin
          low_cnt++;
          if (ck_en || cke) chk(1'b0, "R1", {ck_en, cke}, 0);
        end else begin
          seen_rel = 1; t_rel = t;
          // R1 hold time
          chk(low_cnt >= T_RST, "R1", low_cnt, T_RST);
        end
      end
      if (seen_rel && !seen_ck && ck_en) begin
        seen_ck = 1; t_ck = t;
        chk(t - t_rel == T_CKEW, "R2", t - t_rel, T_CKEW);
      end
      if (seen_ck && !ck_en) chk(1'b0, "R3", ck_en, 1);
      if (!seen_cke && cke) begin
        seen_cke = 1; t_cke = t; t_prev = t;
        odt_ref = odt;
        chk(seen_ck && (t - t_ck == T_CLK), "R3", t - t_ck, T_CLK);
        chk(cs_n == 1'b1, "R4", cs_n, 1);
        chk(odt == exp_odt(mr_vals[1]), "R10", odt, exp_odt(mr_vals[1]));
      end
      if (seen_cke && !cke && !cke_drop) begin
        cke_drop = 1;
        chk(1'b0, "R5", cke, 1);
      end
      if (seen_cke && odt != odt_ref) chk(1'b0, "R10", odt, odt_ref);
      if (!cs_n) begin
        if (n_cmd < 7) begin
          int num = order_at(n_cmd);
          int gap = (n_cmd == 0) ? T_XPR : T_MRD;
          chk({act_n, ras_n, cas_n, we_n} == 4'b1000, (n_cmd == 0) ? "R6" : "R7",
              {act_n, ras_n, cas_n, we_n}, 4'b1000);
          chk({bg, ba} == {1'b0, 3'(num)}, "R7", {bg, ba}, num);
          chk(addr == mr_vals[num], "R6", addr, mr_vals[num]);
          chk(t - t_prev == gap, (n_cmd == 0) ? "R6" : "R7", t - t_prev, gap);
        end else if (n_cmd == 7) begin
          chk({act_n, ras_n, cas_n, we_n} == 4'b1110, "R8", {act_n, ras_n, cas_n, we_n}, 4'b1110);
          chk(addr == (AW'(1) << 10) && bg == 2'b00 && ba == 2'b00, "R8", addr, 1024);
          chk(t - t_prev == T_MOD, "R8", t - t_prev, T_MOD);
          t_zq = t;
        end else begin
          chk(1'b0, "R9", n_cmd + 1, 8);
        end
        t_prev = t;
        n_cmd++;
      end
      if (!seen_done && init_done) begin
        seen_done = 1; t_done = t;
        chk(n_cmd == 8 && (t - t_zq == T_FIN), "R9", t - t_zq, T_FIN);
      end
      if (seen_done && !init_done) chk(1'b0, "R9", init_done, 1);
      if (seen_done && t == t_done + 6) begin
        chk(init_done && cke && cs_n, "R9", {init_done, cke, cs_n}, 7);
        return;
      end
    end
    chk(1'b0, "R9", 0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    mr_flat = '0;
    for (int k = 0; k < 7; k++) mr_vals[k] = '0;
    // Run 1: nominal termination off, ODT expected high (R10)
    load_vals(1'b0);
    run_seq(0);
    // Run 2: reset breaks in during the mode-register writes (R11)
    load_vals(1'b1);
    run_seq(T_RST + T_CKEW + T_CLK + T_XPR + 2 * T_MRD + 2);
    // Run 3: nominal termination on, ODT expected low (R10)
    load_vals(1'b1);
    run_seq(0);
    // Run 4: reset during the reset-hold phase (R1, R11)
    load_vals(1'b0);
    run_seq(5);
    // Run 5: random values again, full sequence
    load_vals(1'($urandom));
    run_seq(0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule